// File: doc/BRIEF.md
# DMA Channel Transfer Counter with Enable Control

This block keeps the transfer count and the run/stop bit for one DMA channel. It sits between the CPU's register writes and the per-unit completion strobe from the DMA engine. It decides what the count becomes and whether the channel keeps running when both sides act in the same cycle.

In normal mode the whole count register is one counter that drops by one per completed transfer. In block mode the upper field holds a fixed block size that hardware never changes, and only the lower field counts completed blocks.

The channel stops by itself when the count reaches zero through a hardware decrement, or when a repeat-area overflow is requested. Both cases raise a same-cycle terminate indication and then a one-cycle end-of-transfer pulse. A CPU request to stop while a unit is in flight is held back until that unit completes.

Top module: `xfer_count_ctl`

## Requirements
- R1: After reset, `cnt` is 0, `en` is 0 and `eot` is 0.
- R2: With `blk_mode`=0 and `en`=1, each `unit_done` lowers the full CW-bit count by one, borrowing across every bit (0x010000 becomes 0x00FFFF).
- R3: With `blk_mode`=1, a `unit_done` lowers only bits BW-1:0 by one, and bits CW-1:BW never change except by a CPU write. A low field of 0 wraps to all ones with no borrow into the size field.
- R4: When `cnt_wr` is high, the next `cnt` equals `cnt_wdata`, even if a hardware decrement happens in the same cycle.
- R5: A `unit_done` while `en`=1 and the counting field equals 1 raises `term` in that cycle. It clears `en` on the next cycle, and `eot` is high for exactly that one next cycle.
- R6: If R5's terminal decrement coincides with a nonzero CPU count write, `cnt` takes the written value and the transfer still ends (`en` cleared, `eot` pulsed).
- R7: A CPU write of 0 to the count neither clears `en` nor raises `term` or `eot`.
- R8: `rpt_ovf` while `en`=1 raises `term`, clears `en` on the next cycle and pulses `eot`. While `en`=0 it has no effect.
- R9: An enable write of 0 (`en_wr`=1, `en_wdata`=0) while `en`=1 and `unit_busy`=1 leaves `en` at 1. The channel is then disabled on the cycle after the next `unit_done`. The same write with `unit_busy`=0 clears `en` on the next cycle.
- R10: An enable write of 1 sets `en` on the next cycle. While `en`=0, `unit_done` leaves `cnt` unchanged.
- R11: `eot` is raised only by hardware ends (R5, R6, R8), never by a CPU disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_mode | input | 1 | 1 = block mode, 0 = normal mode |
| cnt_wr | input | 1 | CPU write strobe for the count |
| cnt_wdata | input | CW | CPU count write value |
| en_wr | input | 1 | CPU write strobe for the enable bit |
| en_wdata | input | 1 | CPU enable write value |
| unit_busy | input | 1 | Engine is in the middle of a unit |
| unit_done | input | 1 | One unit (transfer or block) completed |
| rpt_ovf | input | 1 | Repeat-area overflow request |
| cnt | output | CW | Current count register |
| en | output | 1 | Channel enable |
| term | output | 1 | Same-cycle hardware termination |
| eot | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with its default CW=24 and BW=16. This setting puts the borrow from bit 16 in normal mode against the held size field in block mode at one boundary, so the two modes are told apart by a single strobe. The bench loads small counts so that terminal decrements come within a few cycles. It also loads a size field of all ones with a zero low field, to expose any borrow leaking upward. A reference model in the bench drives the same coincident CPU and hardware events and is compared with the outputs on every cycle.

// File: rtl/xfer_count_ctl.sv
module xfer_count_ctl #(
  parameter int CW = 24,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_mode,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          unit_busy,
  input  logic          unit_done,
  input  logic          rpt_ovf,
  output logic [CW-1:0] cnt,
  output logic          en,
  output logic          term,
  output logic          eot
);

  logic [CW-1:0] cnt_q, dec_val;
  logic [BW-1:0] lo_dec;
  logic          en_q, pend_q, eot_q;
  logic          en_d, pend_d;
  logic          step, at_one;

  assign step   = en_q & unit_done;
  assign lo_dec = cnt_q[BW-1:0] - BW'(1);
  assign at_one = blk_mode ? (cnt_q[BW-1:0] == BW'(1)) : (cnt_q == CW'(1));

  generate
    if (BW < CW) begin : g_split
      assign dec_val = blk_mode ? {cnt_q[CW-1:BW], lo_dec} : cnt_q - CW'(1);
    end else begin : g_flat
      assign dec_val = cnt_q - CW'(1);
    end
  endgenerate

  assign term = en_q & ((unit_done & at_one) | rpt_ovf);

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    if (term) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end else if (en_wr && en_wdata) begin
      en_d   = 1'b1;
      pend_d = 1'b0;
    end else if (en_wr) begin
      if (en_q && unit_busy) begin
        pend_d = 1'b1;
      end else begin
        en_d   = 1'b0;
        pend_d = 1'b0;
      end
    end else if (pend_q && step) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      eot_q  <= 1'b0;
    end else begin
      if (cnt_wr)    cnt_q <= cnt_wdata;
      else if (step) cnt_q <= dec_val;
      en_q   <= en_d;
      pend_q <= pend_d;
      eot_q  <= term;
    end
  end

  assign cnt = cnt_q;
  assign en  = en_q;
  assign eot = eot_q;

endmodule

// File: rtl/xfer_count_ctl_chk.sv
module xfer_count_ctl_chk #(
  parameter int CW = 24,
  parameter int BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_mode,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt_wdata,
  input logic          en_wr,
  input logic          en_wdata,
  input logic          unit_busy,
  input logic          unit_done,
  input logic          rpt_ovf,
  input logic [CW-1:0] cnt,
  input logic          en,
  input logic          term,
  input logic          eot
);

  // R4
  cpu_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(cnt_wdata));

  // R5
  term_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (!en && eot));

  // R11
  eot_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!term) |=> !eot);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt));

  // R3
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && !cnt_wr) |=> cnt[CW-1:BW] == $past(cnt[CW-1:BW]));

  // R9
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_wr && !en_wdata && unit_busy && !term) |=> en);

  // R7
  zero_write_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_wr && cnt_wdata == '0 && !term && !en_wr && !unit_done) |=> en);

endmodule

bind xfer_count_ctl xfer_count_ctl_chk #(.CW(CW), .BW(BW)) u_chk (.*);

// File: tb/sim_xfer_count_ctl.sv
`timescale 1ns/1ps
module sim_xfer_count_ctl;
  localparam int CW = 24;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_mode = 0, cnt_wr = 0, en_wr = 0, en_wdata = 0;
  logic unit_busy = 0, unit_done = 0, rpt_ovf = 0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [CW-1:0] cnt;
  logic en, term, eot;

  int checks = 0, errors = 0;

  logic [23:0] m_cnt;
  logic m_en, m_pend, m_eot;

  always #2 clk = ~clk;

  xfer_count_ctl #(.CW(CW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .unit_busy(unit_busy), .unit_done(unit_done), .rpt_ovf(rpt_ovf),
    .cnt(cnt), .en(en), .term(term), .eot(eot));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit bm, bit cw, int cwd, bit ew, bit ewd,
                     bit busy, bit done, bit ovf);
    int low;
    bit mterm, mdec;
    blk_mode = bm; cnt_wr = cw; cnt_wdata = cwd[23:0]; en_wr = ew;
    en_wdata = ewd; unit_busy = busy; unit_done = done; rpt_ovf = ovf;
    low   = int'(m_cnt) & 'hFFFF;
    mdec  = m_en && done;
    mterm = m_en && ((done && (bm ? low == 1 : m_cnt == 24'd1)) || ovf);
    #1;
    chk(tag, "term", term, mterm);
    @(posedge clk);
    if (cw) m_cnt = cwd[23:0];
    else if (mdec) begin
      if (bm) m_cnt = {m_cnt[23:16], 16'(low - 1)};
      else    m_cnt = m_cnt - 24'd1;
    end
    if (mterm) begin m_en = 0; m_pend = 0; end
    else if (ew && ewd) begin m_en = 1; m_pend = 0; end
    else if (ew) begin
      if (m_en && busy) m_pend = 1;
      else begin m_en = 0; m_pend = 0; end
    end else if (m_pend && mdec) begin m_en = 0; m_pend = 0; end
    m_eot = mterm;
    @(negedge clk);
    chk(tag, "cnt", int'(cnt), int'(m_cnt));
    chk(tag, "en", en, m_en);
    chk(tag, "eot", eot, m_eot);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_cnt = 0; m_en = 0; m_pend = 0; m_eot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "cnt", int'(cnt), 0);
    chk("R1", "en", en, 0);
    chk("R1", "eot", eot, 0);
    // R4 load, R10 done ignored while idle, then start
    cyc("R4", 0, 1, 5, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R10", 0, 0, 0, 1, 1, 0, 0, 0);
    // R2 normal decrement
    cyc("R2", 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R2", 0, 0, 0, 0, 0, 1, 1, 0);
    // R4 write wins over decrement
    cyc("R4", 0, 1, 'h100, 0, 0, 1, 1, 0);
    cyc("R2", 0, 1, 'h010000, 0, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0, 1, 1, 0);
    // R7 zero write keeps channel running
    cyc("R7", 0, 1, 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 terminal decrement
    cyc("R5", 0, 1, 1, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 terminal with nonzero CPU write
    cyc("R6", 0, 1, 1, 1, 1, 0, 0, 0);
    cyc("R6", 0, 1, 'h55, 0, 0, 1, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 block mode
    cyc("R3", 1, 1, 'hFF0002, 1, 1, 0, 0, 0);
    cyc("R3", 1, 0, 0, 0, 0, 1, 1, 0);
    cyc("R3", 1, 0, 0, 0, 0, 1, 1, 0);
    cyc("R3", 1, 1, 'hFF0000, 1, 1, 0, 0, 0);
    cyc("R3", 1, 0, 0, 0, 0, 1, 1, 0);
    cyc("R3", 1, 0, 0, 0, 0, 1, 1, 0);
    // R8 repeat overflow
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    // R9 deferred disable, R11 no eot on CPU stop
    cyc("R9", 0, 1, 10, 1, 1, 0, 0, 0);
    cyc("R9", 0, 0, 0, 1, 0, 1, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 1, 1, 0, 0, 0);
    cyc("R9", 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule